// File: doc/BRIEF.md
# Up/Down Counter with Combined Clear Command

This block is a small synchronous counter. Its state sits in edge-triggered D flip-flops, and all bits load together on each rising clock edge. Two control inputs, `up` and `down`, are decoded together into one of four commands. With neither asserted the count holds. With only `up` asserted the count increments, and with only `down` asserted it decrements. With both asserted the count clears to zero. There is no separate clear pin: the clear is the combination of both controls.

The next state is a purely combinational function of the current count and the decoded command. The count output comes straight from the flip-flops, so it can change only at a clock edge or at reset.

An active-low asynchronous reset forces the count to zero. The width is a parameter and defaults to two bits, which gives counts 0 to 3. Counting wraps modulo 2^WIDTH in both directions.

The decoded commands are named HOLD, INC, DEC and CLR. The single state variable moves between the values 0 to 2^WIDTH-1:
- HOLD is a self-transition.
- INC moves to value+1 and wraps from the maximum to 0.
- DEC moves to value-1 and wraps from 0 to the maximum.
- CLR moves to 0 from every value.

Top module: `updown_clr_counter`

## Requirements
- R1: While `rst_n` is 0, `count` is 0; asserting `rst_n` low sets `count` to 0 at once, without waiting for a clock edge.
- R2: With `up`=0 and `down`=0 at a rising edge (HOLD), `count` keeps its value.
- R3: With `up`=1 and `down`=1 at a rising edge (CLR), `count` becomes 0 whatever its previous value.
- R4: With `up`=1 and `down`=0 at a rising edge (INC), `count` becomes the previous value plus one.
- R5: With `up`=0 and `down`=1 at a rising edge (DEC), `count` becomes the previous value minus one.
- R6: INC from the maximum count (3 at the default width) gives 0.
- R7: DEC from 0 gives the maximum count (3 at the default width).
- R8: `up` and `down` act only at the rising edge: changing them between edges leaves `count` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, forces count to 0 |
| up | input | 1 | Count-up control; with `down` also high it commands a clear |
| down | input | 1 | Count-down control; with `up` also high it commands a clear |
| count | output | WIDTH | Current count, driven directly by the state flip-flops |

## Verification
The bound assertions check, on every cycle out of reset, that the value after each edge matches the command decoded before it. This covers hold, clear, increment and decrement, including the two wrap-around transitions. Only the bench scenarios can show the following behaviours:
- The reset clears the count in the middle of a cycle, with no edge involved.
- Toggling the controls between edges has no effect on the output.
- Long mixed command sequences leave the count at the values computed independently in the bench.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Command decoded from the {up, down} control pair
    typedef enum logic [1:0] {
        CMD_HOLD = 2'b00,
        CMD_DEC  = 2'b01,
        CMD_INC  = 2'b10,
        CMD_CLR  = 2'b11
    } ctr_cmd_e;

endpackage

// File: rtl/ctr_cmd_decode.sv
module ctr_cmd_decode
    import ctr_pkg::*;
(
    input  logic     up,
    input  logic     down,
    output ctr_cmd_e cmd
);

    always_comb begin
        unique case ({up, down})
            2'b00:   cmd = CMD_HOLD;
            2'b01:   cmd = CMD_DEC;
            2'b10:   cmd = CMD_INC;
            default: cmd = CMD_CLR;
        endcase
    end

endmodule

// File: rtl/ctr_next_state.sv
module ctr_next_state
    import ctr_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] cur,
    input  ctr_cmd_e         cmd,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    // Modulo-2^WIDTH arithmetic gives both wrap-arounds for free
    always_comb begin
        unique case (cmd)
            CMD_HOLD: nxt = cur;
            CMD_INC:  nxt = cur + ONE;
            CMD_DEC:  nxt = cur - ONE;
            CMD_CLR:  nxt = ZERO;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // One D flip-flop per state bit; all share the clock edge
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else begin
                q[b] <= d[b];
            end
        end
    end

endmodule

// File: rtl/updown_clr_counter.sv
module updown_clr_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             down,
    output logic [WIDTH-1:0] count
);

    ctr_cmd_e         cmd;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    ctr_cmd_decode u_decode (
        .up   (up),
        .down (down),
        .cmd  (cmd)
    );

    ctr_next_state #(.WIDTH(WIDTH)) u_next (
        .cur (state_q),
        .cmd (cmd),
        .nxt (state_d)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (state_d),
        .q     (state_q)
    );

    assign count = state_q;

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int WIDTH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             up,
    input logic             down,
    input logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] MAXV = '1;

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !down) |=> (count == $past(count)));                       // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (up && down) |=> (count == '0));                                   // R3

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !down) |=> (count == WIDTH'($past(count) + 1'b1)));         // R4

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && down) |=> (count == WIDTH'($past(count) - 1'b1)));         // R5

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !down && count == MAXV) |=> (count == '0));                 // R6

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && down && count == '0) |=> (count == MAXV));                 // R7

endmodule

bind updown_clr_counter ctr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (up),
    .down  (down),
    .count (count)
);

// File: tb/test_updown_clr_counter.sv
module test_updown_clr_counter;

    localparam int WIDTH = 2;
    localparam int NVEC  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             up = 1'b0;
    logic             down = 1'b0;
    logic [WIDTH-1:0] count;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    always #4 clk = ~clk;   // 125 MHz

    updown_clr_counter #(.WIDTH(WIDTH)) i_updown_clr_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (up),
        .down  (down),
        .count (count)
    );

    // Each entry: {up, down, expected count after the edge}, starting from 0
    localparam logic [3:0] VEC [NVEC] = '{
        {2'b10, 2'd1}, {2'b10, 2'd2}, {2'b10, 2'd3}, {2'b10, 2'd0},
        {2'b01, 2'd3}, {2'b01, 2'd2}, {2'b00, 2'd2}, {2'b00, 2'd2},
        {2'b11, 2'd0}, {2'b01, 2'd3}, {2'b11, 2'd0}, {2'b10, 2'd1},
        {2'b00, 2'd1}, {2'b01, 2'd0}, {2'b01, 2'd3}
    };

    function automatic string req_of(input logic [1:0] ud, input logic [1:0] prev);
        case (ud)
            2'b00:   return "R2";
            2'b11:   return "R3";
            2'b10:   return (prev == 2'd3) ? "R6" : "R4";
            default: return (prev == 2'd0) ? "R7" : "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] exp);
        compared++;
        if (count !== exp) begin
            mismatched++;
            $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp, $time);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [WIDTH-1:0] prev;
        // R1: reset state, and edges under reset with up set do nothing
        up = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 2'd0);
        up = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'd0);

        // Vector table walk
        prev = '0;
        for (int i = 0; i < NVEC; i++) begin
            up   = VEC[i][3];
            down = VEC[i][2];
            @(posedge clk);
            @(negedge clk);
            check(req_of(VEC[i][3:2], prev), VEC[i][1:0]);
            prev = VEC[i][1:0];
        end
        // count is now 3

        // R8: controls toggled between edges have no effect before the edge
        up = 1'b0; down = 1'b0;
        #1 up = 1'b1;
        #1 check("R8", 2'd3);
        down = 1'b1;
        #1 check("R8", 2'd3);
        up = 1'b0; down = 1'b0;   // settle on HOLD before the edge
        @(posedge clk);
        @(negedge clk);
        check("R8", 2'd3);

        // R3: clear from a non-zero value reached by decrementing
        down = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R5", 2'd2);
        up = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R3", 2'd0);

        // R1: asynchronous reset mid-cycle, no edge needed
        up = 1'b1; down = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R4", 2'd1);
        #1 rst_n = 1'b0;
        #1 check("R1", 2'd0);
        @(posedge clk); @(negedge clk);
        check("R1", 2'd0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4", 2'd1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule